// File: doc/BRIEF.md
# Four-Channel Packing DMA Controller

This block moves blocks of bytes between addresses on behalf of four independently programmed channels. Every channel owns a source pointer, a destination pointer, a byte count and a control word. A channel either copies data through a 32-bit holding register (dual-address: one or more reads, then one or more writes) or lets a peripheral exchange data directly while the controller drives one write cycle with an acknowledge strobe to that peripheral (single-address). Reads and writes may use different sizes. Narrow reads are packed into the holding register and wide contents are unpacked into narrow writes.

A channel starts either as soon as software arms it, or only while its peripheral request line is high, for example a receive-ready flag. A channel in burst mode keeps the single bus engine until its count runs out. A channel in cycle-steal mode gives the engine back after every chunk, so a more urgent channel can step in. An auto-align option chooses every access size from the pointers and the remaining count. A misaligned block then moves mostly as whole 32-bit words, with narrow accesses only at its head and its tail.

Top module: `dma_pack_top`

## Requirements
- R1: After reset, bus_req is low, dack is all zero, and done_o and irq_o are zero.
- R2: A cycle with cfg_we high writes cfg_wdata into the register that cfg_sel picks for channel cfg_ch: 0 source pointer, 1 destination pointer, 2 byte count, 3 control. The control bits are: 0 arm, 1 single-address, 2 burst, 3 peripheral request, 4 source increment, 5 destination increment, 6 auto-align, 8:7 read size, 10:9 write size, 11 interrupt enable. Size codes are 00 word (4 bytes), 01 byte, 10 halfword. Writing the control register clears that channel's done flag.
- R3: Whenever the engine picks a new chunk and more than one channel is requesting, the channel with the lowest index wins.
- R4: With auto-align off, a dual-address chunk is the larger of the read and write sizes. It is read in read-size units at consecutive offsets into a holding register that keeps the first byte in bits 7:0 and each later byte above it, then written in write-size units taken from the same register. The sequence of written bytes equals the sequence of read bytes. The byte count is expected to be a multiple of the chunk.
- R5: In single-address mode, each chunk is one write cycle of the write size at the destination pointer, with dack bit ch high for that cycle and no read.
- R6: Each pointer advances by the size of the access just completed when its increment bit is set. Otherwise it stays fixed.
- R7: The count drops by the bytes of every completed write. When it reaches zero, the channel disarms and its done flag is set. irq_o is high while any channel has both its done flag and its interrupt enable set.
- R8: A burst channel keeps the engine until its count reaches zero. A cycle-steal channel lets arbitration happen again after every chunk.
- R9: A channel with the peripheral request bit set requests only while its dreq bit is high. Otherwise an armed channel requests at once.
- R10: With auto-align on in dual-address mode, each chunk is one read and one write of the same size u. u is 4 if at least 4 bytes remain and both pointers are word aligned, else 2 if at least 2 remain and both are even, else 1.
- R11: bus_req stays high with address, direction and size unchanged until a cycle with bus_ack high completes the access. Read data is taken right-justified from bus_rdata in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | 2 | Channel addressed by the write |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 32 | Register write data |
| dreq | input | 4 | Peripheral request per channel |
| dack | output | 4 | Peripheral acknowledge during single-address cycles |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | 32 | Access byte address |
| bus_size | output | 2 | Access size code (00 word, 01 byte, 10 half) |
| bus_wdata | output | 32 | Right-justified write data |
| bus_ack | input | 1 | Access completes this cycle |
| bus_rdata | input | 32 | Right-justified read data |
| done_o | output | 4 | Per-channel done flags |
| irq_o | output | 1 | Interrupt request |

## Verification
The interesting collisions are a chunk ending in the same window in which a higher-priority peripheral request rises, and a count running out while another channel is still waiting. The bench raises channel 0's request in the middle of a channel 3 chunk, just after that chunk's read has been acknowledged. It then expects channel 0 to take over at the next chunk boundary when channel 3 is in cycle-steal mode, and to wait until channel 3 finishes when channel 3 is in burst mode. The bench's own channel model predicts the exact order of bus accesses and compares each one at its acknowledge.

// File: rtl/dma_pkg.sv
package dma_pkg;

    localparam int DATA_W = 32;
    localparam int CTL_W  = 12;

    typedef enum logic [1:0] {
        SZ_WORD = 2'b00,
        SZ_BYTE = 2'b01,
        SZ_HALF = 2'b10
    } xsize_e;

    // Control word, bit 0 at the bottom.
    typedef struct packed {
        logic   irq_en;   // 11
        xsize_e wsz;      // 10:9
        xsize_e rsz;      // 8:7
        logic   align;    // 6
        logic   dinc;     // 5
        logic   sinc;     // 4
        logic   hwreq;    // 3
        logic   burst;    // 2
        logic   single;   // 1
        logic   arm;      // 0
    } ctl_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD,
        ST_WR,
        ST_SGL
    } eng_st_e;

    function automatic logic [2:0] bytes_of(input xsize_e s);
        case (s)
            SZ_WORD: bytes_of = 3'd4;
            SZ_HALF: bytes_of = 3'd2;
            default: bytes_of = 3'd1;
        endcase
    endfunction

    function automatic xsize_e code_of(input logic [2:0] nb);
        case (nb)
            3'd4:    code_of = SZ_WORD;
            3'd2:    code_of = SZ_HALF;
            default: code_of = SZ_BYTE;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] lane_mask(input logic [2:0] nb);
        case (nb)
            3'd4:    lane_mask = 32'hFFFF_FFFF;
            3'd2:    lane_mask = 32'h0000_FFFF;
            default: lane_mask = 32'h0000_00FF;
        endcase
    endfunction

endpackage

// File: rtl/dma_arb.sv
module dma_arb #(
    parameter int NCH = 4,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0] req,
    output logic [CHW-1:0] gnt,
    output logic           any
);
    // Fixed priority: lowest index wins.
    always_comb begin
        gnt = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) gnt = CHW'(i);
        end
    end

    assign any = |req;

endmodule

// File: rtl/dma_plan.sv
module dma_plan
    import dma_pkg::*;
#(
    parameter int CNTW = 16
) (
    input  ctl_t            ctl,
    input  logic [1:0]      src_lo,
    input  logic [1:0]      dst_lo,
    input  logic [CNTW-1:0] cnt,
    output logic [2:0]      rd_b,
    output logic [2:0]      wr_b,
    output logic [2:0]      chunk_b
);
    logic [2:0] r_nat;
    logic [2:0] w_nat;
    logic [2:0] unit;

    assign r_nat = bytes_of(ctl.rsz);
    assign w_nat = bytes_of(ctl.wsz);

    // Auto-align unit: largest size both pointers and the remainder allow.
    always_comb begin
        if (cnt >= CNTW'(4) && src_lo == 2'b00 && dst_lo == 2'b00)
            unit = 3'd4;
        else if (cnt >= CNTW'(2) && !src_lo[0] && !dst_lo[0])
            unit = 3'd2;
        else
            unit = 3'd1;
    end

    always_comb begin
        if (ctl.single) begin
            rd_b    = w_nat;
            wr_b    = w_nat;
            chunk_b = w_nat;
        end else if (ctl.align) begin
            rd_b    = unit;
            wr_b    = unit;
            chunk_b = unit;
        end else begin
            rd_b    = r_nat;
            wr_b    = w_nat;
            chunk_b = (r_nat > w_nat) ? r_nat : w_nat;
        end
    end

endmodule

// File: rtl/dma_pack_top.sv
module dma_pack_top
    import dma_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int AW   = 32,
    parameter int CNTW = 16,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CHW-1:0]    cfg_ch,
    input  logic [1:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    input  logic [NCH-1:0]    dreq,
    output logic [NCH-1:0]    dack,
    output logic              bus_req,
    output logic              bus_we,
    output logic [AW-1:0]     bus_addr,
    output logic [1:0]        bus_size,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [NCH-1:0]    done_o,
    output logic              irq_o
);
    // Channel register file
    logic [AW-1:0]   src_q [NCH];
    logic [AW-1:0]   dst_q [NCH];
    logic [CNTW-1:0] cnt_q [NCH];
    ctl_t            ctl_q [NCH];
    logic [NCH-1:0]  done_q;

    // Engine state
    eng_st_e         state;
    logic [CHW-1:0]  cur;
    logic            lock;
    logic [2:0]      rb_q, wb_q, chunk_q, k_q;
    logic [DATA_W-1:0] hold_q;

    logic [NCH-1:0]  req_v;
    logic [NCH-1:0]  ie_v;
    logic [CHW-1:0]  gnt, sel;
    logic            any_req;
    logic [2:0]      p_rb, p_wb, p_chunk;
    logic [2:0]      rd_sum, wr_sum;
    logic [CNTW-1:0] cnt_left;
    logic            align_act;

    for (genvar i = 0; i < NCH; i++) begin : g_req
        assign req_v[i] = ctl_q[i].arm && (!ctl_q[i].hwreq || dreq[i]);
        assign ie_v[i]  = ctl_q[i].irq_en;
        assign dack[i]  = (state == ST_SGL) && (cur == CHW'(i));
    end

    dma_arb #(.NCH(NCH)) u_arb (
        .req (req_v),
        .gnt (gnt),
        .any (any_req)
    );

    assign sel = lock ? cur : gnt;

    dma_plan #(.CNTW(CNTW)) u_plan (
        .ctl     (ctl_q[sel]),
        .src_lo  (src_q[sel][1:0]),
        .dst_lo  (dst_q[sel][1:0]),
        .cnt     (cnt_q[sel]),
        .rd_b    (p_rb),
        .wr_b    (p_wb),
        .chunk_b (p_chunk)
    );

    assign rd_sum   = k_q + rb_q;
    assign wr_sum   = k_q + wb_q;
    assign cnt_left = (cnt_q[cur] > CNTW'(wb_q)) ? cnt_q[cur] - CNTW'(wb_q) : '0;
    assign align_act = ctl_q[cur].align && !ctl_q[cur].single;

    // Bus master outputs
    assign bus_req  = (state != ST_IDLE);
    assign bus_we   = (state == ST_WR) || (state == ST_SGL);
    assign bus_addr = (state == ST_RD) ? src_q[cur] : dst_q[cur];
    assign bus_size = code_of((state == ST_RD) ? rb_q : wb_q);
    assign bus_wdata = (state == ST_WR) ?
                       ((hold_q >> {k_q, 3'b000}) & lane_mask(wb_q)) : '0;

    assign done_o = done_q;
    assign irq_o  = |(done_q & ie_v);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NCH; i++) begin
                src_q[i] <= '0;
                dst_q[i] <= '0;
                cnt_q[i] <= '0;
                ctl_q[i] <= '0;
            end
            done_q  <= '0;
            state   <= ST_IDLE;
            cur     <= '0;
            lock    <= 1'b0;
            rb_q    <= 3'd1;
            wb_q    <= 3'd1;
            chunk_q <= 3'd1;
            k_q     <= '0;
            hold_q  <= '0;
        end else begin
            if (cfg_we) begin
                case (cfg_sel)
                    2'd0: src_q[cfg_ch] <= cfg_wdata[AW-1:0];
                    2'd1: dst_q[cfg_ch] <= cfg_wdata[AW-1:0];
                    2'd2: cnt_q[cfg_ch] <= cfg_wdata[CNTW-1:0];
                    default: begin
                        ctl_q[cfg_ch]  <= ctl_t'(cfg_wdata[CTL_W-1:0]);
                        done_q[cfg_ch] <= 1'b0;
                    end
                endcase
            end

            unique case (state)
                ST_IDLE: begin
                    if (lock || any_req) begin
                        cur     <= sel;
                        rb_q    <= p_rb;
                        wb_q    <= p_wb;
                        chunk_q <= p_chunk;
                        k_q     <= '0;
                        hold_q  <= '0;
                        lock    <= ctl_q[sel].burst;
                        state   <= ctl_q[sel].single ? ST_SGL : ST_RD;
                    end
                end
                ST_RD: begin
                    if (bus_ack) begin
                        hold_q <= hold_q |
                                  ((bus_rdata & lane_mask(rb_q)) << {k_q, 3'b000});
                        if (ctl_q[cur].sinc)
                            src_q[cur] <= src_q[cur] + AW'(rb_q);
                        if (rd_sum >= chunk_q) begin
                            k_q   <= '0;
                            state <= ST_WR;
                        end else begin
                            k_q <= rd_sum;
                        end
                    end
                end
                ST_WR, ST_SGL: begin
                    if (bus_ack) begin
                        if (ctl_q[cur].dinc)
                            dst_q[cur] <= dst_q[cur] + AW'(wb_q);
                        cnt_q[cur] <= cnt_left;
                        if (state == ST_SGL || wr_sum >= chunk_q || cnt_left == '0) begin
                            k_q   <= '0;
                            state <= ST_IDLE;
                            if (cnt_left == '0) begin
                                done_q[cur]    <= 1'b1;
                                ctl_q[cur].arm <= 1'b0;
                                lock           <= 1'b0;
                            end
                        end else begin
                            k_q <= wr_sum;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dma_chk.sv
module dma_chk #(
    parameter int NCH = 4,
    parameter int AW  = 32,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input logic           clk,
    input logic           rst,
    input logic           cfg_we,
    input logic [CHW-1:0] cfg_ch,
    input logic [1:0]     cfg_sel,
    input logic [NCH-1:0] dack,
    input logic           bus_req,
    input logic           bus_we,
    input logic [AW-1:0]  bus_addr,
    input logic [1:0]     bus_size,
    input logic           bus_ack,
    input logic [NCH-1:0] done_o,
    input logic           irq_o,
    input logic           align_act
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_size)); // R11

    AST_DACK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dack)); // R5

    AST_DACK_WRITE: assert property (@(posedge clk) disable iff (rst)
        (|dack) |-> bus_req && bus_we); // R5

    AST_ALIGN_WORD: assert property (@(posedge clk) disable iff (rst)
        bus_req && align_act && bus_size == 2'b00 |-> bus_addr[1:0] == 2'b00); // R10

    AST_ALIGN_HALF: assert property (@(posedge clk) disable iff (rst)
        bus_req && align_act && bus_size == 2'b10 |-> !bus_addr[0]); // R10

    AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (|done_o)); // R7

    for (genvar i = 0; i < NCH; i++) begin : g_done
        AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
            done_o[i] && !(cfg_we && cfg_sel == 2'd3 && cfg_ch == CHW'(i)) |=> done_o[i]); // R7
    end

endmodule

bind dma_pack_top dma_chk #(.NCH(NCH), .AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_ch    (cfg_ch),
    .cfg_sel   (cfg_sel),
    .dack      (dack),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .bus_ack   (bus_ack),
    .done_o    (done_o),
    .irq_o     (irq_o),
    .align_act (align_act)
);

// File: tb/tb_dma_pack_top.sv
module tb_dma_pack_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_ch = '0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [3:0]  dreq = '0;
    logic [3:0]  dack;
    logic        bus_req, bus_we;
    logic [31:0] bus_addr;
    logic [1:0]  bus_size;
    logic [31:0] bus_wdata;
    logic        bus_ack = 1'b0;
    logic [31:0] bus_rdata = '0;
    logic [3:0]  done_o;
    logic        irq_o;

    always #10 clk = ~clk;

    dma_pack_top dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .dreq(dreq), .dack(dack), .bus_req(bus_req),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .done_o(done_o), .irq_o(irq_o)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int ack_cnt = 0;
    int wcnt = 0;
    int lat = 0;
    string cur_tag = "R1";

    typedef struct {
        logic [31:0] a;
        bit          we;
        int          n;
        int          dk;
    } txn_t;

    txn_t        eq[$];
    logic [7:0]  bq[$];

    // Behavioural channel model
    int unsigned ms[4], md[4], mc[4];
    int          m_ss[4], m_ds[4];
    bit          m_single[4], m_sinc[4], m_dinc[4], m_align[4];
    logic [31:0] mctl[4];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        return 8'(a[7:0] * 8'd37 + 8'd11);
    endfunction

    function automatic logic [1:0] code(input int n);
        return (n == 4) ? 2'b00 : (n == 2) ? 2'b10 : 2'b01;
    endfunction

    function automatic int nbytes(input logic [1:0] c);
        return (c == 2'b00) ? 4 : (c == 2'b10) ? 2 : 1;
    endfunction

    // Bus slave and per-access comparison against the model
    always @(negedge clk) begin
        if (rst) begin
            bus_ack = 1'b0;
            wcnt = 0;
        end else if (bus_req) begin
            if (wcnt >= lat) begin
                txn_t        e;
                int          n;
                logic [31:0] w;
                logic [3:0]  edk;
                n = nbytes(bus_size);
                bus_ack = 1'b1;
                if (eq.size() == 0) begin
                    chk(1'b0, cur_tag, "unexpected access at", bus_addr, 32'h0);
                end else begin
                    e = eq.pop_front();
                    edk = (e.dk >= 0) ? 4'(1 << e.dk) : 4'b0;
                    chk(bus_addr == e.a, cur_tag, "address", bus_addr, e.a);
                    chk(bus_we == e.we && n == e.n, cur_tag, "dir/size",
                        {bus_we, 31'(n)}, {e.we, 31'(e.n)});
                    chk(dack == edk, cur_tag, "dack", 32'(dack), 32'(edk));
                    if (!bus_we) begin
                        w = '0;
                        for (int j = 0; j < n; j++) begin
                            w[8*j +: 8] = mem_byte(bus_addr + 32'(j));
                            bq.push_back(w[8*j +: 8]);
                        end
                        bus_rdata = w;
                    end else if (e.dk < 0) begin
                        w = '0;
                        for (int j = 0; j < n; j++)
                            if (bq.size() > 0) w[8*j +: 8] = bq.pop_front();
                        chk(bus_wdata == w, cur_tag, "write data", bus_wdata, w);
                    end
                end
                ack_cnt++;
                wcnt = 0;
                lat = ack_cnt % 3;
            end else begin
                bus_ack = 1'b0;
                wcnt++;
            end
        end else begin
            bus_ack = 1'b0;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=0", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic push_t(input logic [31:0] a, input bit we, input int n, input int dk);
        txn_t t;
        t.a = a; t.we = we; t.n = n; t.dk = dk;
        eq.push_back(t);
    endtask

    task automatic exp_chunk(input int ch);
        int rb, wb, ck, u;
        if (m_single[ch]) begin
            push_t(md[ch], 1'b1, m_ds[ch], ch);
            if (m_dinc[ch]) md[ch] += m_ds[ch];
            mc[ch] -= m_ds[ch];
            return;
        end
        if (m_align[ch]) begin
            u = 1;
            if (mc[ch] >= 4 && ms[ch] % 4 == 0 && md[ch] % 4 == 0) u = 4;
            else if (mc[ch] >= 2 && ms[ch] % 2 == 0 && md[ch] % 2 == 0) u = 2;
            rb = u; wb = u; ck = u;
        end else begin
            rb = m_ss[ch]; wb = m_ds[ch];
            ck = (rb > wb) ? rb : wb;
        end
        for (int o = 0; o < ck; o += rb) begin
            push_t(ms[ch], 1'b0, rb, -1);
            if (m_sinc[ch]) ms[ch] += rb;
        end
        for (int o = 0; o < ck; o += wb) begin
            push_t(md[ch], 1'b1, wb, -1);
            if (m_dinc[ch]) md[ch] += wb;
        end
        mc[ch] -= ck;
    endtask

    task automatic exp_all(input int ch);
        while (mc[ch] > 0) exp_chunk(ch);
    endtask

    task automatic wr(input int ch, input int sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_sel = 2'(sel); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic setup(input int ch, input int unsigned s, input int unsigned d,
                         input int unsigned n, input bit single, input bit burst,
                         input bit hw, input bit sinc, input bit dinc, input bit align,
                         input int ss, input int ds, input bit ie);
        ms[ch] = s; md[ch] = d; mc[ch] = n;
        m_ss[ch] = ss; m_ds[ch] = ds; m_single[ch] = single;
        m_sinc[ch] = sinc; m_dinc[ch] = dinc; m_align[ch] = align;
        mctl[ch] = {20'b0, ie, code(ds), code(ss), align, dinc, sinc, hw, burst, single, 1'b1};
        wr(ch, 0, s);
        wr(ch, 1, d);
        wr(ch, 2, n);
    endtask

    task automatic arm(input int ch);
        wr(ch, 3, mctl[ch]);
    endtask

    task automatic wait_done(input string tag);
        int t = 0;
        while ((eq.size() != 0 || bus_req) && t < 3000) begin
            @(negedge clk);
            t++;
        end
        repeat (3) @(negedge clk);
        chk(t < 3000, tag, "block did not finish, pending", 32'(eq.size()), 32'h0);
        chk(eq.size() == 0 && !bus_req, tag, "idle after block", 32'(eq.size()), 32'h0);
    endtask

    initial begin
        int base;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!bus_req && dack == 4'b0, "R1", "bus idle in reset", {dack, 27'b0, bus_req}, 32'h0);
        chk(done_o == 4'b0 && !irq_o, "R1", "flags in reset", {done_o, irq_o}, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(!bus_req && done_o == 4'b0 && !irq_o, "R1", "idle after reset", {done_o, irq_o}, 32'h0);

        // R4 packing: bytes in, words out, burst, software start
        cur_tag = "R4";
        setup(0, 32'h10, 32'h40, 8, 0, 1, 0, 1, 1, 0, 1, 4, 1);
        exp_all(0);
        arm(0);
        wait_done("R4");
        chk(done_o == 4'b0001, "R7", "done after count zero", 32'(done_o), 32'h1);
        chk(irq_o == 1'b1, "R7", "irq with enable", 32'(irq_o), 32'h1);
        wr(0, 3, 32'h0);
        @(negedge clk);
        chk(done_o == 4'b0 && !irq_o, "R2", "control write clears done", {done_o, irq_o}, 32'h0);

        // R4 unpacking: words in, halfwords out, no interrupt enable
        cur_tag = "R4";
        setup(0, 32'h20, 32'h60, 8, 0, 0, 0, 1, 1, 0, 4, 2, 0);
        exp_all(0);
        arm(0);
        wait_done("R4");
        chk(done_o == 4'b0001 && !irq_o, "R7", "done without irq", {done_o, irq_o}, 32'h2);
        wr(0, 3, 32'h0);

        // R10 auto-align on a misaligned 10-byte block: 1,2,4,2,1
        cur_tag = "R10";
        setup(2, 32'h41, 32'h81, 10, 0, 1, 0, 1, 1, 1, 4, 4, 0);
        exp_all(2);
        arm(2);
        wait_done("R10");
        chk(done_o == 4'b0100, "R10", "aligned block done", 32'(done_o), 32'h4);
        wr(2, 3, 32'h0);

        // R5/R6/R9 single-address, fixed destination, peripheral request
        cur_tag = "R5";
        setup(1, 32'h0, 32'h90, 4, 1, 0, 1, 0, 0, 0, 2, 2, 0);
        exp_all(1);
        arm(1);
        repeat (6) @(negedge clk);
        chk(!bus_req, "R9", "no access while dreq low", 32'(bus_req), 32'h0);
        dreq[1] = 1'b1;
        wait_done("R5");
        chk(done_o == 4'b0010, "R6", "fixed-destination block done", 32'(done_o), 32'h2);
        dreq = '0;
        wr(1, 3, 32'h0);

        // R3 priority: channels 1 and 2 requested together
        cur_tag = "R3";
        setup(2, 32'h08, 32'hA0, 8, 0, 0, 1, 1, 1, 0, 4, 4, 0);
        setup(1, 32'h30, 32'hC0, 8, 0, 0, 1, 1, 1, 0, 4, 4, 0);
        exp_all(1);
        exp_all(2);
        arm(2);
        arm(1);
        @(negedge clk);
        dreq = 4'b0110;
        wait_done("R3");
        chk(done_o == 4'b0110, "R3", "both channels done", 32'(done_o), 32'h6);
        dreq = '0;
        wr(1, 3, 32'h0);
        wr(2, 3, 32'h0);

        // R8 cycle steal: channel 0 cuts in between channel 3 chunks
        cur_tag = "R8";
        setup(0, 32'h50, 32'hE0, 4, 0, 0, 1, 1, 1, 0, 4, 4, 0);
        setup(3, 32'h70, 32'hF0, 12, 0, 0, 1, 1, 1, 0, 4, 4, 0);
        exp_chunk(3); exp_chunk(0); exp_chunk(3); exp_chunk(3);
        arm(0);
        arm(3);
        base = ack_cnt;
        dreq[3] = 1'b1;
        wait (ack_cnt == base + 1);
        @(negedge clk);
        dreq[0] = 1'b1;
        wait_done("R8");
        chk(done_o == 4'b1001, "R8", "cycle-steal pair done", 32'(done_o), 32'h9);
        dreq = '0;
        wr(0, 3, 32'h0);
        wr(3, 3, 32'h0);

        // R8 burst: channel 3 keeps the engine, channel 0 waits
        cur_tag = "R8";
        setup(0, 32'h50, 32'hE0, 4, 0, 0, 1, 1, 1, 0, 4, 4, 0);
        setup(3, 32'h70, 32'hF0, 12, 0, 1, 1, 1, 1, 0, 4, 4, 0);
        exp_all(3);
        exp_all(0);
        arm(0);
        arm(3);
        base = ack_cnt;
        dreq[3] = 1'b1;
        wait (ack_cnt == base + 1);
        @(negedge clk);
        dreq[0] = 1'b1;
        wait_done("R8");
        chk(done_o == 4'b1001, "R8", "burst pair done", 32'(done_o), 32'h9);
        chk(!bus_req && dack == 4'b0, "R11", "bus released", 32'(bus_req), 32'h0);
        dreq = '0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule